// File: doc/BRIEF.md
# Physical memory protection checker

This block decides whether one access to a physical address may proceed. It is purely combinational. It takes one 32-bit byte address, the privilege level (machine or user) and the access kind (instruction fetch, data load or data store). It weighs them against eight protection entries. Each entry has an 8-bit configuration field and a 32-bit address register, and the register holds a byte address shifted right by two.

Every entry is tested against the address at the same time. The lowest-numbered entry that matches is the only one whose permissions count. An entry describes its region in one of four ways:

- disabled;
- top-of-range, bounded below by the previous entry's register;
- a single naturally aligned 4-byte word;
- a naturally aligned power-of-two region, whose size comes from the trailing ones of the register.

The block returns a grant flag. On a denial it also returns the access-fault cause code that the trap logic should record. A core places one copy on the fetch path and one on each data path, with all copies sharing the same configuration inputs.

Top module: `pmp_guard`

## Requirements
- R1: When several entries match an address, only the lowest-numbered matching entry decides the outcome, and all higher-numbered entries are ignored.
- R2: An entry whose mode field is 00 (disabled) never matches, whatever its register and permission bits hold.
- R3: Mode 01 (top-of-range) matches when prev*4 <= addr < own*4, where prev is the previous entry's register and zero for entry 0; an entry whose own*4 is at or below prev*4 matches nothing.
- R4: Mode 10 matches exactly the four bytes from own*4 to own*4+3.
- R5: Mode 11 covers a naturally aligned region of 2^(T+3) bytes, where T is the count of trailing ones in the register; for example, 0x0FFFFFFF covers 0x00000000 to 0x7FFFFFFF and nothing at or above 0x80000000.
- R6: Entry i's configuration sits in cfg_bank bits [8i+7:8i] with bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = mode, bit 7 = lock; bits 6:5 have no effect. Entry i's register sits in addr_bank bits [32i+31:32i].
- R7: When no entry matches, a machine-mode access (priv_m = 1) is granted and a user-mode access (priv_m = 0) is denied.
- R8: A user-mode access that hits an entry is granted only if that entry's permission bit for the access kind is set.
- R9: A machine-mode access that hits an unlocked entry is always granted; one that hits a locked entry is checked against that entry's permission bits, exactly as a user-mode access is.
- R10: fault_cause is 0 when the access is granted; on a denial it is 1 for a fetch, 5 for a load and 7 for a store.
- R11: acc_kind 00 is a fetch and is checked against execute, 01 is a load and is checked against read, and 10 is a store and is checked against write; 11 is handled exactly as a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_bank | input | 64 | Eight packed 8-bit entry configuration fields, with entry 0 in the low byte |
| addr_bank | input | 256 | Eight packed 32-bit entry address registers (byte address divided by four), with entry 0 in the low word |
| addr | input | 32 | Physical byte address under test |
| priv_m | input | 1 | 1 = machine mode, 0 = user mode |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 store |
| grant | output | 1 | 1 when the access may proceed |
| fault_cause | output | 4 | Exception cause on denial (1, 5 or 7), 0 when granted |

## Verification
The bench probes the exclusive upper bound of each top-of-range region and the exact last byte of each power-of-two region. A checker that is off by one at these edges would grant or deny the neighbouring word. It uses an inverted top-of-range pair below an entry that forbids execution, so a comparator that ignores the lower bound would turn a denied fetch into a grant. A disabled entry whose register spans all of memory catches a decoder that lets mode 00 match. It tests overlapping entries with conflicting permissions, locked versus unlocked hits in machine mode, and the two different no-match defaults. A priority or privilege error shows up there as a store or fetch that is granted when it should trap, or the reverse.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int unsigned CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd7;

  typedef enum logic [1:0] {
    AM_OFF   = 2'b00,
    AM_TOR   = 2'b01,
    AM_NA4   = 2'b10,
    AM_NAPOT = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_SPARE = 2'b11
  } acc_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsv;
    amode_e     amode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

  localparam int unsigned CFG_W = $bits(ent_cfg_t);

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_chk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  amode_e        amode,
  input  logic [AW-1:0] own_reg,
  input  logic [AW-1:0] prev_reg,
  output logic          hit
);

  localparam int unsigned BW = AW + 2;

  function automatic logic tor_hit(input logic [AW-1:0] a,
                                   input logic [AW-1:0] lo_w,
                                   input logic [AW-1:0] hi_w);
    logic [BW-1:0] ab, lo, hi;
    ab = {2'b00, a};
    lo = {lo_w, 2'b00};
    hi = {hi_w, 2'b00};
    return (ab >= lo) && (ab < hi);
  endfunction

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] a);
    return {2'b00, a[AW-1:2]};
  endfunction

  function automatic logic na4_hit(input logic [AW-1:0] a,
                                   input logic [AW-1:0] r);
    return word_of(a) == r;
  endfunction

  function automatic logic [AW-1:0] napot_keep(input logic [AW-1:0] r);
    return ~(r ^ (r + 1'b1));
  endfunction

  function automatic logic napot_hit(input logic [AW-1:0] a,
                                     input logic [AW-1:0] r);
    return ((word_of(a) ^ r) & napot_keep(r)) == '0;
  endfunction

  always_comb begin
    unique case (amode)
      AM_TOR:   hit = tor_hit(addr, prev_reg, own_reg);
      AM_NA4:   hit = na4_hit(addr, own_reg);
      AM_NAPOT: hit = napot_hit(addr, own_reg);
      default:  hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({amode, own_reg, prev_reg, addr, hit})) begin
      if (amode == AM_OFF)
        assert_off_silent_R2: assert (!hit)
          else $error("disabled entry reported a hit");
      if (amode == AM_TOR && own_reg <= prev_reg)
        assert_tor_empty_R3: assert (!hit)
          else $error("inverted range reported a hit");
    end
  end

endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] win,
  output logic         any_hit
);

  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    logic [N-1:0] o;
    logic         seen;
    o = '0;
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && !seen) begin
        o[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return o;
  endfunction

  assign win     = lowest_set(hits);
  assign any_hit = |hits;

  always_comb begin
    if (!$isunknown({hits, win, any_hit})) begin
      assert_single_win_R1: assert ($onehot0(win))
        else $error("more than one winning entry");
      assert_win_is_hit_R1: assert ((win & ~hits) == '0)
        else $error("winner did not match");
      assert_win_lowest_R1: assert ((hits & (win - 1'b1)) == '0 || win == '0)
        else $error("lower-numbered hit was skipped");
      assert_win_present_R1: assert (any_hit == (win != '0))
        else $error("hit present but no winner");
    end
  end

endmodule

// File: rtl/pmp_verdict.sv
module pmp_verdict
  import pmp_chk_pkg::*;
(
  input  logic               any_hit,
  input  ent_cfg_t           sel,
  input  logic               priv_m,
  input  acc_e               kind,
  output logic               allow,
  output logic [CAUSE_W-1:0] cause
);

  function automatic logic perm_for(input ent_cfg_t c, input acc_e k);
    unique case (k)
      ACC_FETCH: return c.x;
      ACC_LOAD:  return c.r;
      default:   return c.w;
    endcase
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_for(input acc_e k);
    unique case (k)
      ACC_FETCH: return CAUSE_FETCH;
      ACC_LOAD:  return CAUSE_LOAD;
      default:   return CAUSE_STORE;
    endcase
  endfunction

  logic bypass_m;
  logic rsv_unused;

  assign rsv_unused = ^sel.rsv ^ ^sel.amode;
  assign bypass_m   = priv_m && !sel.lock;

  always_comb begin
    if (!any_hit)      allow = priv_m;
    else if (bypass_m) allow = 1'b1;
    else               allow = perm_for(sel, kind);
  end

  assign cause = allow ? CAUSE_NONE : cause_for(kind);

  always_comb begin
    if (!$isunknown({any_hit, sel, priv_m, kind, allow, cause})) begin
      if (!any_hit && priv_m)
        assert_nomatch_m_R7: assert (allow)
          else $error("machine default denied");
      if (!any_hit && !priv_m)
        assert_nomatch_u_R7: assert (!allow)
          else $error("user default granted");
      if (any_hit && priv_m && !sel.lock)
        assert_unlocked_m_R9: assert (allow)
          else $error("unlocked machine access denied");
      if (allow)
        assert_cause_clear_R10: assert (cause == CAUSE_NONE)
          else $error("cause set on grant");
      else
        assert_cause_legal_R10: assert (cause == CAUSE_FETCH ||
                                        cause == CAUSE_LOAD ||
                                        cause == CAUSE_STORE)
          else $error("illegal cause on deny");
    end
  end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_chk_pkg::*;
#(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned AW    = 32
) (
  input  logic [N_ENT*CFG_W-1:0] cfg_bank,
  input  logic [N_ENT*AW-1:0]    addr_bank,
  input  logic [AW-1:0]          addr,
  input  logic                   priv_m,
  input  logic [1:0]             acc_kind,
  output logic                   grant,
  output logic [CAUSE_W-1:0]     fault_cause
);

  ent_cfg_t          cfg_e  [N_ENT];
  logic [AW-1:0]     reg_e  [N_ENT];
  logic [N_ENT-1:0]  hits;
  logic [N_ENT-1:0]  win;
  logic              any_hit;
  ent_cfg_t          sel_cfg;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign cfg_e[i] = ent_cfg_t'(cfg_bank[i*CFG_W +: CFG_W]);
    assign reg_e[i] = addr_bank[i*AW +: AW];

    logic [AW-1:0] lower;
    if (i == 0) begin : g_base
      assign lower = '0;
    end else begin : g_prev
      assign lower = addr_bank[(i-1)*AW +: AW];
    end

    pmp_entry_match #(.AW(AW)) u_match (
      .addr     (addr),
      .amode    (cfg_e[i].amode),
      .own_reg  (reg_e[i]),
      .prev_reg (lower),
      .hit      (hits[i])
    );
  end

  pmp_prio_pick #(.N(N_ENT)) u_pick (
    .hits    (hits),
    .win     (win),
    .any_hit (any_hit)
  );

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < N_ENT; i++)
      if (win[i]) sel_cfg = sel_cfg | cfg_e[i];
  end

  pmp_verdict u_verdict (
    .any_hit (any_hit),
    .sel     (sel_cfg),
    .priv_m  (priv_m),
    .kind    (acc_e'(acc_kind)),
    .allow   (grant),
    .cause   (fault_cause)
  );

  always_comb begin
    if (!$isunknown({acc_kind, grant, fault_cause}) && !grant) begin
      if (acc_kind == 2'b00)
        assert_fetch_code_R10: assert (fault_cause == CAUSE_FETCH)
          else $error("fetch deny code wrong");
      if (acc_kind == 2'b01)
        assert_load_code_R10: assert (fault_cause == CAUSE_LOAD)
          else $error("load deny code wrong");
      if (acc_kind[1])
        assert_store_code_R11: assert (fault_cause == CAUSE_STORE)
          else $error("store deny code wrong");
    end
  end

endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N*8-1:0]  cfg_bank;
  logic [N*AW-1:0] addr_bank;
  logic [AW-1:0]   addr;
  logic            priv_m;
  logic [1:0]      acc_kind;
  logic            grant;
  logic [3:0]      fault_cause;

  int applied = 0;
  int bad     = 0;

  pmp_guard u0 (
    .cfg_bank    (cfg_bank),
    .addr_bank   (addr_bank),
    .addr        (addr),
    .priv_m      (priv_m),
    .acc_kind    (acc_kind),
    .grant       (grant),
    .fault_cause (fault_cause)
  );

  // {addr, priv_m, kind, exp_grant, exp_cause, requirement}
  localparam logic [47:0] VEC [0:NV-1] = '{
    {32'h0000_0100, 1'b0, 2'd0, 1'b1, 4'd0, 8'd3},   // R3 fetch in code range
    {32'h0000_0100, 1'b0, 2'd2, 1'b0, 4'd7, 8'd1},   // R1 entry 0 beats entry 7
    {32'h0000_0FFC, 1'b0, 2'd1, 1'b1, 4'd0, 8'd3},   // R3 last word below top
    {32'h0000_1000, 1'b0, 2'd0, 1'b0, 4'd1, 8'd3},   // R3 top exclusive
    {32'h0000_1FFC, 1'b0, 2'd2, 1'b1, 4'd0, 8'd8},   // R8 write allowed
    {32'h0000_2000, 1'b0, 2'd2, 1'b1, 4'd0, 8'd3},   // R3 past entry 1
    {32'h0000_3000, 1'b0, 2'd1, 1'b1, 4'd0, 8'd4},   // R4 exact word
    {32'h0000_3002, 1'b0, 2'd2, 1'b0, 4'd7, 8'd4},   // R4 byte inside word
    {32'h0000_3004, 1'b0, 2'd2, 1'b1, 4'd0, 8'd4},   // R4 next word
    {32'h0000_401C, 1'b0, 2'd0, 1'b1, 4'd0, 8'd5},   // R5 top of 32B region
    {32'h0000_401C, 1'b0, 2'd1, 1'b0, 4'd5, 8'd5},   // R5 execute-only region
    {32'h0000_4020, 1'b0, 2'd1, 1'b1, 4'd0, 8'd5},   // R5 just past region
    {32'h0000_2004, 1'b0, 2'd0, 1'b0, 4'd1, 8'd3},   // R3 inverted range empty
    {32'h0000_8004, 1'b1, 2'd2, 1'b0, 4'd7, 8'd9},   // R9 locked, machine
    {32'h0000_8004, 1'b1, 2'd1, 1'b1, 4'd0, 8'd9},   // R9 locked read ok
    {32'h0000_8008, 1'b0, 2'd2, 1'b1, 4'd0, 8'd5},   // R5 8B region end
    {32'h0000_0100, 1'b1, 2'd2, 1'b1, 4'd0, 8'd9},   // R9 unlocked machine
    {32'h9000_0000, 1'b1, 2'd0, 1'b1, 4'd0, 8'd7},   // R7 machine default
    {32'h9000_0000, 1'b0, 2'd1, 1'b0, 4'd5, 8'd7},   // R7 user default
    {32'h7FFF_FFFC, 1'b0, 2'd2, 1'b1, 4'd0, 8'd6},   // R6 reserved bits ignored
    {32'h8000_0000, 1'b0, 2'd2, 1'b0, 4'd7, 8'd5},   // R5 2GiB upper edge
    {32'h0000_0100, 1'b0, 2'd3, 1'b0, 4'd7, 8'd11}   // R11 kind 11 as store
  };

  task automatic set_entry(input int i, input logic [7:0] c, input logic [31:0] r);
    cfg_bank[i*8 +: 8]    = c;
    addr_bank[i*AW +: AW] = r;
  endtask

  task automatic probe(input logic [31:0] a, input logic pm, input logic [1:0] k,
                       input logic eg, input logic [3:0] ec, input int req);
    @(posedge clk);
    addr = a; priv_m = pm; acc_kind = k;
    @(negedge clk);
    applied++;
    if (grant !== eg || fault_cause !== ec) begin
      bad++;
      $display("FAIL R%0d addr=%h priv_m=%0d kind=%0d: got grant=%0d cause=%0d, expected grant=%0d cause=%0d",
               req, a, pm, k, grant, fault_cause, eg, ec);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    cfg_bank = '0; addr_bank = '0; addr = '0; priv_m = 1'b0; acc_kind = 2'b00;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state, all entries off: R7 defaults, R10 code
    probe(32'h0000_0040, 1'b0, 2'd1, 1'b0, 4'd5, 7);
    probe(32'h0000_0040, 1'b1, 2'd2, 1'b1, 4'd0, 7);

    // Table configuration (R6 layout)
    set_entry(0, 8'h0D, 32'h0000_0400);   // TOR RX, below 0x1000
    set_entry(1, 8'h0B, 32'h0000_0800);   // TOR RW, 0x1000..0x1FFF
    set_entry(2, 8'h11, 32'h0000_0C00);   // NA4 R, 0x3000
    set_entry(3, 8'h1C, 32'h0000_1003);   // NAPOT X, 0x4000..0x401F
    set_entry(4, 8'h0F, 32'h0000_1000);   // TOR RWX, inverted -> empty
    set_entry(5, 8'h99, 32'h0000_2000);   // NAPOT R locked, 0x8000..0x8007
    set_entry(6, 8'h07, 32'hFFFF_FFFF);   // OFF, would span all memory
    set_entry(7, 8'h7B, 32'h0FFF_FFFF);   // NAPOT RW, reserved bits set

    for (int k = 0; k < NV; k++)
      probe(VEC[k][47:16], VEC[k][15], VEC[k][14:13], VEC[k][12],
            VEC[k][11:8], int'(VEC[k][7:0]));

    // R2: disabled entry spanning memory does not match
    probe(32'hF000_0000, 1'b0, 2'd1, 1'b0, 4'd5, 2);

    // R3: entry 0 lower bound is zero
    cfg_bank = '0; addr_bank = '0;
    set_entry(0, 8'h09, 32'h0000_0010);
    probe(32'h0000_0000, 1'b0, 2'd1, 1'b1, 4'd0, 3);
    probe(32'h0000_0040, 1'b0, 2'd1, 1'b0, 4'd5, 3);

    // R8: write-only word, each kind
    set_entry(0, 8'h12, 32'h0000_0040);
    probe(32'h0000_0100, 1'b0, 2'd2, 1'b1, 4'd0, 8);
    probe(32'h0000_0100, 1'b0, 2'd1, 1'b0, 4'd5, 8);
    probe(32'h0000_0100, 1'b0, 2'd0, 1'b0, 4'd1, 8);

    // R9: lock toggles machine enforcement
    set_entry(0, 8'h92, 32'h0000_0040);
    probe(32'h0000_0100, 1'b1, 2'd0, 1'b0, 4'd1, 9);
    set_entry(0, 8'h12, 32'h0000_0040);
    probe(32'h0000_0100, 1'b1, 2'd0, 1'b1, 4'd0, 9);

    // R1: lower entry with no rights shadows later RWX entry
    set_entry(0, 8'h18, 32'h0000_0047);
    set_entry(1, 8'h1F, 32'h0FFF_FFFF);
    probe(32'h0000_0104, 1'b0, 2'd1, 1'b0, 4'd5, 1);
    probe(32'h0000_0204, 1'b0, 2'd1, 1'b1, 4'd0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule